// File: doc/BRIEF.md
# Programmable Interval Timer with Modulus

This block is a 16-bit down-counting interval timer. It is used as a periodic tick source for an interrupt controller. A power-of-two prescaler paces the counter from half the system clock. When the count reaches zero the counter reloads, either from a software-written modulus or from the full value 0xFFFF. Each reload sets a sticky event flag, and the interrupt output is that flag gated by an enable bit.

Software reaches the block over a single-cycle synchronous register port with three halfword locations: control and status, modulus, and a read-only live count. Because of a few rules, software can manage the interrupt without disturbing the timing. A write of 1 clears the flag. A control write that changes only the interrupt enable leaves the prescaler and counter running. An overwrite option makes a modulus write take effect in the counter at once.

Top module: `pit_timer`

## Requirements
- R1: After reset, control reads 0x0000, modulus reads 0xFFFF, count reads 0xFFFF and `irqOut` is 0.
- R2: While control bit 0 (enable) is 1, the count changes once every 2·2^P clocks, where P is control bits 11:8. While enable is 0 and no modulus overwrite happens, the count holds.
- R3: A prescaled tick that finds the count at 0x0000 is a terminal count. On that tick the count loads the modulus when control bit 1 (reload) is 1, and loads 0xFFFF when it is 0. Any other tick decrements the count by one.
- R4: Every terminal count sets control bit 2 (flag). `irqOut` is 1 exactly when control bit 2 and control bit 3 (interrupt enable) are both 1.
- R5: A control write with data bit 2 set clears the flag, and one with bit 2 clear leaves it unchanged. If a terminal count falls in the same cycle as the clear, the flag stays set.
- R6: A control write whose stored bits differ from the current value only in bit 3 (ignoring bit 2) does not disturb the prescaler phase or the count.
- R7: Any other control write restarts the prescaler phase from zero. The count keeps its value, and counting continues under the new settings if enable is 1.
- R8: A modulus write stores the value and clears the flag. When control bit 4 (overwrite) is 1, the count equals the written value on the next cycle. When it is 0, the count is untouched and the new modulus is used at the next reload.
- R9: Byte offset 0 is control, 2 is modulus and 4 is the count. Writes to offset 4 are ignored, and reads of any other offset return 0. Read data is combinational from the address.
- R10: Control stores bits 0, 1, 3–6 and 8–11 as written. Bits 5 and 6 have no effect on counting. All other bits read 0.
- R11: If a modulus write with overwrite lands on a terminal count, the written value wins over the reload, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Byte offset of the register access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr` |
| irqOut | output | 1 | Interrupt request, flag AND enable |

## Verification
The counter's terminal count can land in the same cycle as a software write that also acts on the flag or the count. The two collision cases are a write-1-to-clear control write and a modulus write with overwrite. The bench sweeps the write's issue cycle across every prescaler phase, so some write is certain to coincide with a terminal count. A behavioural reference model runs alongside the design, and the interrupt line and read data are compared against it every clock. The model encodes set-over-clear for the flag and overwrite-over-reload for the count.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int SEL_W  = 4;
  localparam int ADDR_W = 3;

  // control bit positions (decoded by software, so fixed)
  localparam int BIT_EN   = 0;
  localparam int BIT_RLD  = 1;
  localparam int BIT_FLAG = 2;
  localparam int BIT_IE   = 3;
  localparam int BIT_OVW  = 4;
  localparam int SEL_LO   = 8;

  typedef struct packed {
    logic             enable;
    logic [SEL_W-1:0] preSel;
    logic             restart;
    logic             loadCount;
    logic [CNT_W-1:0] loadValue;
    logic [CNT_W-1:0] reloadValue;
  } pitStrobes_t;
endpackage

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pitStrobes_t      strobes,
  output logic [CNT_W-1:0] countQ,
  output logic             tcEvent
);
  localparam int PHASE_W = 1 << SEL_W;

  logic [PHASE_W-1:0] phaseQ;
  logic [PHASE_W:0]   phaseLimit;
  logic               tick;

  // half system clock, then 2^P: last phase index is 2*2^P - 1
  assign phaseLimit = ((PHASE_W+1)'(2) << strobes.preSel) - (PHASE_W+1)'(1);
  assign tick    = strobes.enable && !strobes.restart &&
                   ({1'b0, phaseQ} == phaseLimit);
  assign tcEvent = tick && (countQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= '0;
    end else if (strobes.restart || tick) begin
      phaseQ <= '0;
    end else if (strobes.enable) begin
      phaseQ <= phaseQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '1;
    end else if (strobes.loadCount) begin
      countQ <= strobes.loadValue;
    end else if (tcEvent) begin
      countQ <= strobes.reloadValue;
    end else if (tick) begin
      countQ <= countQ - 1'b1;
    end
  end

  p_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tcEvent && !strobes.loadCount) |=> countQ == $past(strobes.reloadValue));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.enable && !strobes.loadCount) |=> $stable(countQ));
  p_phase_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> phaseQ == '0);
  p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enable |-> {1'b0, phaseQ} <= phaseLimit);
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [CNT_W-1:0]  busWdata,
  input  logic              tcEvent,
  input  logic [CNT_W-1:0]  countVal,
  output pitStrobes_t       strobes,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_MOD   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_COUNT = ADDR_W'(4);
  localparam logic [CNT_W-1:0]  KEEP_MASK = CNT_W'(16'h0F7B);
  localparam logic [CNT_W-1:0]  QUIET_MASK = KEEP_MASK & ~(CNT_W'(1) << BIT_IE);

  logic [CNT_W-1:0] ctrlQ, modQ, ctrlNext;
  logic wrCtl, wrMod, flagNext, restart;

  assign wrCtl = busWe && (busAddr == OFS_CTRL);
  assign wrMod = busWe && (busAddr == OFS_MOD);
  assign restart = wrCtl && (((ctrlQ ^ busWdata) & QUIET_MASK) != '0);

  always_comb begin
    flagNext = ctrlQ[BIT_FLAG];
    if (wrCtl && busWdata[BIT_FLAG]) flagNext = 1'b0;
    if (wrMod)                       flagNext = 1'b0;
    if (tcEvent)                     flagNext = 1'b1;
    ctrlNext = wrCtl ? (busWdata & KEEP_MASK) : ctrlQ;
    ctrlNext[BIT_FLAG] = flagNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      modQ  <= '1;
    end else begin
      ctrlQ <= ctrlNext;
      if (wrMod) modQ <= busWdata;
    end
  end

  always_comb begin
    strobes.enable      = ctrlQ[BIT_EN];
    strobes.preSel      = ctrlQ[SEL_LO +: SEL_W];
    strobes.restart     = restart;
    strobes.loadCount   = wrMod && ctrlQ[BIT_OVW];
    strobes.loadValue   = busWdata;
    strobes.reloadValue = ctrlQ[BIT_RLD] ? modQ : '1;
  end

  always_comb begin
    case (busAddr)
      OFS_CTRL:  busRdata = ctrlQ;
      OFS_MOD:   busRdata = modQ;
      OFS_COUNT: busRdata = countVal;
      default:   busRdata = '0;
    endcase
  end

  assign irqOut = ctrlQ[BIT_FLAG] & ctrlQ[BIT_IE];

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    tcEvent |=> ctrlQ[BIT_FLAG]);
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl && busWdata[BIT_FLAG] && !tcEvent) |=> !ctrlQ[BIT_FLAG]);
  p_mod_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrMod && !tcEvent) |=> !ctrlQ[BIT_FLAG]);
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[BIT_FLAG] && !busWe) |=> ctrlQ[BIT_FLAG]);
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irqOut
);
  pitStrobes_t      strobes;
  logic [CNT_W-1:0] countVal;
  logic             tcEvent;

  pit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .tcEvent(tcEvent), .countVal(countVal),
    .strobes(strobes), .busRdata(busRdata), .irqOut(irqOut)
  );

  pit_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .countQ(countVal), .tcEvent(tcEvent)
  );

  // R8 and R11: overwrite beats reload and decrement
  p_ovw_load_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCount |=> countVal == $past(busWdata));
endmodule

// File: tb/sim_pit_timer.sv
module sim_pit_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = 3'd4;
  logic        busWe = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit live = 1'b0;
  string curReq = "R1";

  // reference state
  logic [15:0] mCtrl, mMod, mCnt;
  int          mPhase;

  pit_timer u0 (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
                .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 16'h0000; mMod = 16'hFFFF; mCnt = 16'hFFFF; mPhase = 0;
    end else begin
      bit wc, wm, rs, tk, tc, fl;
      int span;
      wc = busWe && busAddr == 3'd0;
      wm = busWe && busAddr == 3'd2;
      rs = wc && (((mCtrl ^ busWdata) & 16'h0F73) != 0);
      span = 2 * (1 << mCtrl[11:8]);
      tk = mCtrl[0] && !rs && (mPhase == span - 1);
      tc = tk && mCnt == 0;
      fl = mCtrl[2];
      if (wc && busWdata[2]) fl = 0;
      if (wm) fl = 0;
      if (tc) fl = 1;
      if (wm && mCtrl[4]) mCnt = busWdata;
      else if (tc) mCnt = mCtrl[1] ? mMod : 16'hFFFF;
      else if (tk) mCnt = mCnt - 1;
      if (rs || tk) mPhase = 0;
      else if (mCtrl[0]) mPhase = mPhase + 1;
      if (wm) mMod = busWdata;
      if (wc) mCtrl = busWdata & 16'h0F7B;
      mCtrl[2] = fl;
    end
  end

  function automatic logic [15:0] modelRead(logic [2:0] a);
    case (a)
      3'd0: return mCtrl;
      3'd2: return mMod;
      3'd4: return mCnt;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    #3;
    if (live) begin
      checks++;
      if (busRdata !== modelRead(busAddr)) begin
        failures++;
        $display("FAIL %s: read @%0d actual %h expected %h", curReq, busAddr,
                 busRdata, modelRead(busAddr));
      end
      checks++;
      if (irqOut !== (mCtrl[2] & mCtrl[3])) begin
        failures++;
        $display("FAIL %s: irqOut actual %b expected %b", curReq, irqOut,
                 mCtrl[2] & mCtrl[3]);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0; busAddr = 3'd4;
  endtask

  task automatic idle(input int n, input logic [2:0] a);
    @(negedge clk); busAddr = a;
    repeat (n) @(negedge clk);
    busAddr = 3'd4;
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    live = 1'b1;                      // R1 checks under reset
    curReq = "R1"; idle(1, 3'd0); idle(1, 3'd2); idle(1, 3'd4);
    @(negedge clk); rstN = 1'b1;
    idle(2, 3'd0); idle(1, 3'd2);

    // R2 R3 R4: reload mode, divide by 2, interrupt enabled
    curReq = "R3";
    wr(3'd2, 16'd5);
    wr(3'd0, 16'h000B);
    idle(40, 3'd4); idle(2, 3'd0);

    // R5 R6: clear flag and toggle IE without restart
    curReq = "R6";
    wr(3'd0, 16'h000F); idle(3, 3'd4);
    wr(3'd0, 16'h0003); idle(5, 3'd0);
    wr(3'd0, 16'h000B); idle(20, 3'd4);
    curReq = "R5";
    wr(3'd0, 16'h0003); idle(4, 3'd0);

    // R7: prescaler P=3 restarts phase
    curReq = "R7";
    wr(3'd0, 16'h030B); idle(150, 3'd4); idle(2, 3'd0);
    wr(3'd0, 16'h020B); idle(60, 3'd4);

    // R2: disabled count holds
    curReq = "R2";
    wr(3'd0, 16'h0008); idle(30, 3'd4);

    // R8: overwrite in free-run mode, then reload from 0xFFFF
    curReq = "R8";
    wr(3'd0, 16'h0019);
    wr(3'd2, 16'd3); idle(12, 3'd4); idle(2, 3'd0);
    wr(3'd0, 16'h000B);
    wr(3'd2, 16'd2); idle(4, 3'd4);   // no overwrite: takes effect at reload
    idle(20, 3'd4);

    // R9 R10: read-only count, unused offsets, stored bits
    curReq = "R9";
    wr(3'd4, 16'h1234); idle(3, 3'd4);
    idle(2, 3'd6); idle(2, 3'd1);
    curReq = "R10";
    wr(3'd0, 16'hF06B); idle(2, 3'd0); idle(20, 3'd4);

    // R11 and R5 collisions: sweep write phase over a full period
    curReq = "R11";
    wr(3'd0, 16'h001B);
    for (int k = 0; k < 8; k++) begin
      wr(3'd2, 16'd1);
      idle(k + 1, 3'd4);
      wr(3'd2, 16'd1);
      idle(2, 3'd0);
    end
    curReq = "R5";
    wr(3'd0, 16'h000B); wr(3'd2, 16'd1);
    for (int k = 0; k < 8; k++) begin
      idle(k + 1, 3'd4);
      wr(3'd0, 16'h000F);
      idle(2, 3'd0);
    end

    live = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule